// File: doc/BRIEF.md
# GPIO Pin Slice with Input Filter and Interrupt Detection

This block is the logic behind a single general-purpose I/O pin. A 32-bit control word chooses which peripheral function drives the pin's output value and its output enable. It also sets a separate 2-bit override for each of four paths: output value, output enable, input to peripherals, and interrupt. A second, read-only word reports the input at several points along its conditioning chain. Both words are reached through a plain single-cycle register port. Writes take effect at the clock edge. Reads are combinational on the address.

The pad input passes through a two-flop synchroniser. After that comes a stability filter whose hold time can be programmed. Eight interrupt sources are built from the synchronised and filtered signals, and each has its own enable:

- rising and falling edges of the synchronised input,
- high and low levels of the synchronised input,
- rising and falling edges of the filtered input,
- high and low levels of the filtered ("debounced") input.

Edge sources are latched. Software clears all edge latches with a write-one command bit. Level sources need no acknowledge.

There is no data stream through this slice, so every port is a plain control or status signal with no valid/ready handshake. The register port never stalls.

Top module: `gpio_pin_slice`

## Requirements
- R1: After reset the control word reads 0x0000001F (no function selected, every other field 0), and `pad_out`, `pad_oe` and `irq` are 0.
- R2: Control bits [4:0] select a function. A value from 0 to NUM_FUNC-1 (default 9, so 0..8) routes `func_out[sel]` and `func_oe[sel]` to the override stage. Index 5 is where the software-driven GPIO source is attached. Any other value, including 31, feeds value 0 and enable 0.
- R3: Control bits [13:12] set the output override: 0 passes the selected value, 1 inverts it, 2 forces 0, 3 forces 1. The result appears on `pad_out` in the same cycle.
- R4: Control bits [15:14] apply the same four encodings (pass, invert, force 0, force 1) to the selected enable, giving `pad_oe`.
- R5: Control bits [17:16] apply the same four encodings to the synchronised input. The result drives `periph_in` and status bit 19.
- R6: Status bit 16 is the raw pad input with no delay. Status bit 17 is the synchronised input, which follows the pad two clock edges later.
- R7: Control bits [11:5] hold a filter constant M (0..127). The filtered input (status bit 18) takes the synchronised value at the (M+1)-th consecutive edge at which the two differ, which is M+3 edges after a pad change. Any return to agreement restarts the count, so a pad pulse of M cycles is rejected and one of M+1 cycles passes.
- R8: Control bits 20 and 21 enable the falling and rising edge sources on the synchronised input. An edge sets its latch one edge after it appears on status bit 17, but only while its enable is set. The latch holds until cleared, and `irq` reflects enabled latches.
- R9: Control bits 22 and 23 enable the level-low and level-high sources on the synchronised input. These follow the level directly, with no latch, and deassert when the level goes away.
- R10: Control bits 24 and 25 enable the falling and rising edge sources on the filtered input, latched as in R8. Bits 26 and 27 enable level-low and level-high sources on the filtered input, unlatched.
- R11: Writing 1 to control bit 28 clears every edge latch. An enabled edge event seen in that same cycle wins and leaves its latch set. Bit 28 always reads 0.
- R12: Control bits [31:30] apply the four override encodings to the OR of all enabled sources, giving `irq`.
- R13: Control bits 18, 19, 28 and 29 read 0 whatever was written to them. Status bits other than 16..19 read 0. A write to the status address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, qualified by bus_sel |
| bus_addr | input | 1 | 0 = control word, 1 = status word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| func_out | input | NUM_FUNC | Output value offered by each function |
| func_oe | input | NUM_FUNC | Output enable offered by each function |
| pad_in | input | 1 | Asynchronous pad input |
| pad_out | output | 1 | Value driven to the pad |
| pad_oe | output | 1 | Output enable driven to the pad |
| periph_in | output | 1 | Conditioned input for peripherals |
| irq | output | 1 | Interrupt request of this pin |

## Verification
A stuck or miscounting filter counter shows up on status bit 18 within M+3 cycles of a pad change. It can also let a pulse of exactly M cycles through, or block one of M+1 cycles. A corrupted edge latch or a wrong prior-value register shows up on `irq` at the edge right after the event: the request rises one cycle early or late, fires without an enable, or falls without a clear. A wrong function or override decode is visible on `pad_out`, `pad_oe` and `periph_in` in the same cycle as the control write, and the bench sweeps every select and override combination.

// File: rtl/gpio_slice_pkg.sv
package gpio_slice_pkg;

  // control word layout
  localparam int SEL_LSB    = 0;
  localparam int SEL_W      = 5;
  localparam int FILT_LSB   = 5;
  localparam int FILT_W     = 7;
  localparam int OUTOV_LSB  = 12;
  localparam int OEOV_LSB   = 14;
  localparam int INOV_LSB   = 16;
  localparam int IRQEN_LSB  = 20;
  localparam int IRQ_SRCS   = 8;
  localparam int IRQCLR_BIT = 28;
  localparam int IRQOV_LSB  = 30;

  // status word layout
  localparam int ST_RAW  = 16;
  localparam int ST_SYNC = 17;
  localparam int ST_FILT = 18;
  localparam int ST_PERI = 19;

  // bits that hold state: reserved bits and the clear command read 0
  localparam logic [31:0] CTRL_KEEP  = 32'hCFF3_FFFF;
  localparam logic [31:0] CTRL_RESET = 32'h0000_001F;

  typedef enum logic [1:0] {
    OV_PASS   = 2'd0,
    OV_INVERT = 2'd1,
    OV_LOW    = 2'd2,
    OV_HIGH   = 2'd3
  } ovr_mode_e;

  function automatic logic ovr_apply(input logic [1:0] mode, input logic v);
    logic r;
    case (ovr_mode_e'(mode))
      OV_PASS:   r = v;
      OV_INVERT: r = ~v;
      OV_LOW:    r = 1'b0;
      default:   r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/gp_out_mux.sv
module gp_out_mux
  import gpio_slice_pkg::*;
#(
  parameter int NUM_FUNC = 9,
  parameter int SW       = 5
) (
  input  logic [SW-1:0]       fsel,
  input  logic [1:0]          out_mode,
  input  logic [1:0]          oe_mode,
  input  logic [NUM_FUNC-1:0] fn_out,
  input  logic [NUM_FUNC-1:0] fn_oe,
  output logic                pin_out,
  output logic                pin_oe
);

  logic sel_out;
  logic sel_oe;

  // unselected or out-of-range codes leave value and enable at 0
  always_comb begin
    sel_out = 1'b0;
    sel_oe  = 1'b0;
    for (int i = 0; i < NUM_FUNC; i++) begin
      if (fsel == SW'(i)) begin
        sel_out = fn_out[i];
        sel_oe  = fn_oe[i];
      end
    end
  end

  assign pin_out = ovr_apply(out_mode, sel_out);
  assign pin_oe  = ovr_apply(oe_mode, sel_oe);

endmodule

// File: rtl/gp_in_cond.sv
module gp_in_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int CW          = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pad,
  input  logic [CW-1:0] hold_m,
  output logic          sync,
  output logic          filt
);

  logic [SYNC_STAGES-1:0] chain;
  logic [CW-1:0]          cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[SYNC_STAGES-2:0], pad};
  end

  assign sync = chain[SYNC_STAGES-1];

  // count edges of disagreement; accept after hold_m+1 of them
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      filt <= 1'b0;
    end else if (sync == filt) begin
      cnt <= '0;
    end else if (cnt >= hold_m) begin
      filt <= sync;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  p_sync_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chain[SYNC_STAGES-1] == $past(chain[SYNC_STAGES-2]));

  p_filt_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (filt != $past(filt)) |-> ($past(sync) != $past(filt)));

  p_filt_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (filt != $past(filt)) |-> ($past(cnt) >= $past(hold_m)));

endmodule

// File: rtl/gp_irq_detect.sv
module gp_irq_detect #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sync,
  input  logic            filt,
  input  logic [NSRC-1:0] en,
  input  logic            clr,
  output logic [NSRC-1:0] active
);

  logic            sync_d;
  logic            filt_d;
  logic [NSRC-1:0] lat;
  logic [NSRC-1:0] hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_d <= 1'b0;
      filt_d <= 1'b0;
    end else begin
      sync_d <= sync;
      filt_d <= filt;
    end
  end

  // source i: i<4 on synchronised input, else on filtered input;
  // i%4 in {0,1} is an edge (latched), {2,3} a level; odd i is the high/rising sense
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam bit RAW  = (i < 4);
    localparam bit UP   = (i % 2) == 1;
    localparam bit EDGE = (i % 4) < 2;
    logic cur;
    assign cur = RAW ? sync : filt;
    if (EDGE) begin : g_edge
      logic prv;
      logic q;
      assign prv    = RAW ? sync_d : filt_d;
      assign hit[i] = en[i] & (UP ? (cur & ~prv) : (~cur & prv));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= 1'b0;
        else if (hit[i]) q <= 1'b1;
        else if (clr)    q <= 1'b0;
      end
      assign lat[i]    = q;
      assign active[i] = en[i] & q;
    end else begin : g_level
      assign hit[i]    = 1'b0;
      assign lat[i]    = 1'b0;
      assign active[i] = en[i] & (UP ? cur : ~cur);
    end
  end

  p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(lat) & ~lat) & {NSRC{~$past(clr)}}) == '0);

  p_latch_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> ((lat & ~$past(hit)) == '0));

  p_latch_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((lat & ~$past(lat) & ~$past(en)) == '0));

endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
  import gpio_slice_pkg::*;
#(
  parameter int NUM_FUNC    = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic                bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_FUNC-1:0] func_out,
  input  logic [NUM_FUNC-1:0] func_oe,
  input  logic                pad_in,
  output logic                pad_out,
  output logic                pad_oe,
  output logic                periph_in,
  output logic                irq
);

  localparam logic [SEL_W-1:0] SEL_LIMIT = SEL_W'(NUM_FUNC);

  logic [31:0]         ctrl_q;
  logic                wr_ctrl;
  logic                clr_edges;
  logic [SEL_W-1:0]    f_sel;
  logic [FILT_W-1:0]   f_hold;
  logic [1:0]          f_outov, f_oeov, f_inov, f_irqov;
  logic [IRQ_SRCS-1:0] f_en;
  logic                in_sync, in_filt;
  logic [IRQ_SRCS-1:0] src_active;
  logic [31:0]         status_w;

  assign wr_ctrl   = bus_sel & bus_wr & ~bus_addr;
  assign clr_edges = wr_ctrl & bus_wdata[IRQCLR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= CTRL_RESET;
    else if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_KEEP;
  end

  assign f_sel   = ctrl_q[SEL_LSB +: SEL_W];
  assign f_hold  = ctrl_q[FILT_LSB +: FILT_W];
  assign f_outov = ctrl_q[OUTOV_LSB +: 2];
  assign f_oeov  = ctrl_q[OEOV_LSB +: 2];
  assign f_inov  = ctrl_q[INOV_LSB +: 2];
  assign f_en    = ctrl_q[IRQEN_LSB +: IRQ_SRCS];
  assign f_irqov = ctrl_q[IRQOV_LSB +: 2];

  gp_out_mux #(.NUM_FUNC(NUM_FUNC), .SW(SEL_W)) u_mux (
    .fsel     (f_sel),
    .out_mode (f_outov),
    .oe_mode  (f_oeov),
    .fn_out   (func_out),
    .fn_oe    (func_oe),
    .pin_out  (pad_out),
    .pin_oe   (pad_oe)
  );

  gp_in_cond #(.SYNC_STAGES(SYNC_STAGES), .CW(FILT_W)) u_cond (
    .clk    (clk),
    .rst_n  (rst_n),
    .pad    (pad_in),
    .hold_m (f_hold),
    .sync   (in_sync),
    .filt   (in_filt)
  );

  gp_irq_detect #(.NSRC(IRQ_SRCS)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync   (in_sync),
    .filt   (in_filt),
    .en     (f_en),
    .clr    (clr_edges),
    .active (src_active)
  );

  assign periph_in = ovr_apply(f_inov, in_sync);
  assign irq       = ovr_apply(f_irqov, |src_active);

  always_comb begin
    status_w          = '0;
    status_w[ST_RAW]  = pad_in;
    status_w[ST_SYNC] = in_sync;
    status_w[ST_FILT] = in_filt;
    status_w[ST_PERI] = periph_in;
  end

  assign bus_rdata = bus_addr ? status_w : ctrl_q;

  p_null_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((f_sel >= SEL_LIMIT) && (f_outov == 2'd0) && (f_oeov == 2'd0)) |-> (!pad_out && !pad_oe));

  p_level_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (f_en[3] && in_sync && (f_irqov == 2'd0)) |-> irq);

  p_clr_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_addr |-> !bus_rdata[IRQCLR_BIT]);

  p_status_write_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr) |=> (ctrl_q == $past(ctrl_q)));

endmodule

// File: tb/sim_gpio_pin_slice.sv
`timescale 1ns/1ps
module sim_gpio_pin_slice;
  localparam int NF = 9;
  localparam logic [31:0] BASE = 32'h1F;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NF-1:0] fo = '0, fe = '0;
  logic          pad = 1'b0;
  logic          pad_out, pad_oe, periph_in, irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit reported = 0;

  always #2.5 clk = ~clk;

  gpio_pin_slice #(.NUM_FUNC(NF), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .func_out(fo), .func_oe(fe), .pad_in(pad), .pad_out(pad_out),
    .pad_oe(pad_oe), .periph_in(periph_in), .irq(irq)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic settle(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  function automatic logic ov(input int m, input logic v);
    case (m)
      0: return v;
      1: return ~v;
      2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [31:0] d;
    logic [NF-1:0] pa, qa;
    bit seen;
    pa = 9'b1_0110_1001;
    qa = 9'b0_1100_1110;

    // R1 reset state
    settle(3);
    rst_n = 1'b1;
    tick();
    rd(1'b0, d); chk("R1 ctrl reset", d, BASE);
    chk("R1 pad_out", pad_out, 0);
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 irq", irq, 0);

    // R2 R3 R4 full sweep of select and output overrides
    for (int fs = 0; fs < 32; fs++)
      for (int om = 0; om < 4; om++)
        for (int em = 0; em < 4; em++) begin
          wr(1'b0, 32'(fs) | (32'(om) << 12) | (32'(em) << 14));
          for (int p = 0; p < 2; p++) begin
            logic sv, se;
            fo = p ? ~pa : pa;
            fe = p ? ~qa : qa;
            #1;
            sv = (fs < NF) ? fo[fs] : 1'b0;
            se = (fs < NF) ? fe[fs] : 1'b0;
            chk($sformatf("R2 R3 out sel=%0d om=%0d", fs, om), pad_out, ov(om, sv));
            chk($sformatf("R2 R4 oe sel=%0d em=%0d", fs, em), pad_oe, ov(em, se));
          end
        end

    // R5 R6 input override and status taps
    for (int im = 0; im < 4; im++)
      for (int v = 0; v < 2; v++) begin
        wr(1'b0, BASE | (32'(im) << 16));
        pad = v[0];
        settle(3);
        rd(1'b1, d);
        chk("R5 periph_in", periph_in, ov(im, v[0]));
        chk("R5 status peri", d[19], ov(im, v[0]));
        chk("R6 status sync", d[17], v[0]);
        chk("R6 status raw", d[16], v[0]);
      end

    // R6 latency
    wr(1'b0, BASE); pad = 1'b0; settle(4);
    pad = 1'b1; #1;
    rd(1'b1, d); chk("R6 raw immediate", d[16], 1);
    tick(); rd(1'b1, d); chk("R6 sync not yet", d[17], 0);
    tick(); rd(1'b1, d); chk("R6 sync after two", d[17], 1);
    pad = 1'b0; settle(4);

    // R7 filter sweep
    for (int m = 0; m < 7; m++) begin
      pad = 1'b0;
      wr(1'b0, BASE | (32'(m) << 5));
      settle(10);
      pad = 1'b1;
      for (int k = 1; k <= m + 3; k++) begin
        tick();
        rd(1'b1, d);
        if (k == m + 2) chk($sformatf("R7 filt early m=%0d", m), d[18], 0);
        if (k == m + 3) chk($sformatf("R7 filt follows m=%0d", m), d[18], 1);
      end
      pad = 1'b0; settle(m + 6);
      rd(1'b1, d); chk("R7 filt returns", d[18], 0);
      if (m >= 1) begin
        pad = 1'b1; settle(m); pad = 1'b0;
        seen = 0;
        for (int k = 0; k < 2 * m + 6; k++) begin tick(); rd(1'b1, d); if (d[18]) seen = 1; end
        chk($sformatf("R7 short pulse rejected m=%0d", m), seen, 0);
      end
      pad = 1'b1; settle(m + 1); pad = 1'b0;
      seen = 0;
      for (int k = 0; k < 2 * m + 6; k++) begin tick(); rd(1'b1, d); if (d[18]) seen = 1; end
      chk($sformatf("R7 long pulse passes m=%0d", m), seen, 1);
    end

    // R8 raw rising edge latched
    pad = 1'b0; wr(1'b0, BASE | (1 << 21)); settle(4);
    pad = 1'b1;
    settle(2); chk("R8 rise not yet", irq, 0);
    tick();    chk("R8 rise latched", irq, 1);
    pad = 1'b0; settle(5); chk("R8 rise held", irq, 1);
    wr(1'b0, BASE | (1 << 21) | (1 << 28));
    chk("R11 clear", irq, 0);
    rd(1'b0, d); chk("R11 bit28 reads 0", d, BASE | (1 << 21));

    // R8 raw falling edge
    wr(1'b0, BASE | (1 << 20));
    pad = 1'b1; settle(5); chk("R8 no fall on rise", irq, 0);
    pad = 1'b0;
    settle(2); chk("R8 fall not yet", irq, 0);
    tick();    chk("R8 fall latched", irq, 1);
    wr(1'b0, BASE | (1 << 20) | (1 << 28)); chk("R11 clear fall", irq, 0);

    // R8 no latch while disabled
    wr(1'b0, BASE);
    pad = 1'b1; settle(5);
    wr(1'b0, BASE | (1 << 21)); chk("R8 disabled edge ignored", irq, 0);
    pad = 1'b0; settle(5);

    // R9 level sources
    wr(1'b0, BASE | (1 << 23));
    pad = 1'b1; tick(); chk("R9 high not yet", irq, 0);
    tick(); chk("R9 high follows", irq, 1);
    pad = 1'b0; tick(); chk("R9 high still", irq, 1);
    tick(); chk("R9 high released", irq, 0);
    wr(1'b0, BASE | (1 << 22)); chk("R9 low active", irq, 1);
    pad = 1'b1; settle(2); chk("R9 low released", irq, 0);
    pad = 1'b0; settle(4);

    // R10 filtered edges and debounced levels, M=3
    wr(1'b0, BASE | (3 << 5) | (1 << 25)); settle(8);
    pad = 1'b1;
    settle(6); chk("R10 filt rise not yet", irq, 0);
    tick();    chk("R10 filt rise latched", irq, 1);
    pad = 1'b0; settle(10); chk("R10 filt rise held", irq, 1);
    wr(1'b0, BASE | (3 << 5) | (1 << 24) | (1 << 28)); chk("R11 clear filt", irq, 0);
    pad = 1'b1; settle(10); chk("R10 no filt fall on rise", irq, 0);
    pad = 1'b0;
    settle(6); chk("R10 filt fall not yet", irq, 0);
    tick();    chk("R10 filt fall latched", irq, 1);
    wr(1'b0, BASE | (3 << 5) | (1 << 27) | (1 << 28)); chk("R10 db high idle", irq, 0);
    pad = 1'b1;
    settle(5); chk("R10 db high not yet", irq, 0);
    tick();    chk("R10 db high", irq, 1);
    wr(1'b0, BASE | (3 << 5) | (1 << 26)); chk("R10 db low idle", irq, 0);
    pad = 1'b0; settle(6); chk("R10 db low", irq, 1);
    wr(1'b0, BASE | (3 << 5) | (1 << 27)); settle(4);
    pad = 1'b1; settle(3); pad = 1'b0;
    seen = 0;
    for (int k = 0; k < 10; k++) begin tick(); if (irq) seen = 1; end
    chk("R10 db glitch rejected", seen, 0);

    // R11 event in the clearing cycle wins
    wr(1'b0, BASE | (1 << 21) | (1 << 28)); settle(4);
    pad = 1'b1; settle(2);
    wr(1'b0, BASE | (1 << 21) | (1 << 28));
    chk("R11 set beats clear", irq, 1);
    wr(1'b0, BASE | (1 << 21) | (1 << 28));
    chk("R11 later clear", irq, 0);

    // R12 interrupt override (pad is high here)
    wr(1'b0, BASE | (32'd3 << 30)); chk("R12 force high", irq, 1);
    wr(1'b0, BASE | (1 << 23) | (32'd2 << 30)); chk("R12 force low", irq, 0);
    wr(1'b0, BASE | (32'd1 << 30)); chk("R12 invert idle", irq, 1);
    wr(1'b0, BASE | (1 << 23) | (32'd1 << 30)); chk("R12 invert active", irq, 0);

    // R13 reserved bits and status writes
    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b0, d); chk("R13 reserved read 0", d, 32'hCFF3_FFFF);
    wr(1'b1, 32'h0);
    rd(1'b0, d); chk("R13 status write ignored", d, 32'hCFF3_FFFF);
    rd(1'b1, d); chk("R13 status unused bits", d & ~32'h000F_0000, 32'h0);

    report();
  end
endmodule